// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits in the receive path of an Ethernet MAC. It decides whether a frame is accepted by hash matching on the 48-bit destination address. The address arrives one byte per accepted cycle, first byte first. While the bytes come in, the filter folds the address into a 6-bit index. When the sixth byte arrives, it uses that index to pick one bit out of a 64-bit hash table. The table is supplied as a low and a high 32-bit word.

The table hit is then qualified by the group bit of the address. Unicast frames need the unicast hash enable and multicast frames need the multicast hash enable. Two overrides apply on top of the hash result. A copy-all mode accepts any frame. The all-ones broadcast address is accepted unless broadcast reception is switched off.

The filter gives one decision per frame, as a single-cycle pulse. The pulse carries an accept flag and the group (multicast) indication.

Top module: `dahash_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_multicast` are low. Bytes received before the first byte marked with `rx_sof` produce no decision.
- R2: An address is six bytes taken on cycles with `rx_valid` high, with `rx_sof` high on the first byte. `dec_valid` is high for exactly the one cycle that follows the clock edge sampling the sixth byte. Further bytes produce no new decision until the next `rx_sof`.
- R3: Address bit 8*i+j is bit j of byte i, where byte 0 is received first. Index bit k (0..5) is the XOR of address bits k, k+6, k+12, ... up to k+42.
- R4: Index value n selects bit n of the 64-bit table. `hash_lo` holds table bits 31:0 and `hash_hi` holds table bits 63:32.
- R5: A frame whose address bit 0 is 1 is accepted when `cfg_multi_en` is 1 and the indexed table bit is 1.
- R6: A frame whose address bit 0 is 0 is accepted when `cfg_uni_en` is 1 and the indexed table bit is 1. The multicast enable alone never accepts it.
- R7: When all 64 table bits and `cfg_multi_en` are set, every multicast address is accepted.
- R8: `cfg_copy_all` = 1 accepts every frame, whatever the table and enables hold.
- R9: The all-ones address is accepted when `cfg_bcast_reject` is 0. When it is 1, that address is judged by the multicast hash rule like any other.
- R10: During the decision cycle, `dec_multicast` equals address bit 0. Outside it, `dec_accept` and `dec_multicast` are low.
- R11: Idle cycles (`rx_valid` low) may separate the address bytes without changing the result. An `rx_sof` byte arriving before the sixth byte restarts the address, and the partial one is dropped.
- R12: The configuration inputs and the table are used as they stand at the clock edge that samples the sixth byte. Changes after that edge do not alter that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | `rx_byte` carries a received byte this cycle |
| rx_sof | input | 1 | The byte is the first of a destination address |
| rx_byte | input | 8 | Received byte |
| cfg_uni_en | input | 1 | Enable hash acceptance of unicast frames |
| cfg_multi_en | input | 1 | Enable hash acceptance of multicast frames |
| cfg_copy_all | input | 1 | Accept every frame |
| cfg_bcast_reject | input | 1 | Do not accept broadcast unconditionally |
| hash_lo | input | 32 | Hash table bits 31:0 |
| hash_hi | input | 32 | Hash table bits 63:32 |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with the strobe) |
| dec_multicast | output | 1 | Address group bit (valid with the strobe) |

## Verification
The hardest thing to show from the ports is that each address bit lands in the right index position. This matters most for the bytes whose bit lanes start at offsets 2 and 4 within the 6-bit fold. The stimulus walks every 6-bit pattern through each of the eight 6-bit slots of the address. For each case, the table holds a single set bit at either the expected index or its neighbour, so a misrouted bit turns into a wrong accept.

A second corner is a configuration change that lands exactly on the edge that takes the sixth byte. The bench produces it by driving the new setting on the same half cycle as the final byte, and it also tests a restart marker in the middle of an address.

// File: rtl/dahf_pkg.sv
package dahf_pkg;
    localparam int ADDR_W    = 48;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 6;
    localparam int NUM_BYTES = ADDR_W / BYTE_W;
    localparam int HASH_BITS = 1 << IDX_W;
    localparam int WORD_W    = HASH_BITS / 2;
    localparam int CNT_W     = $clog2(NUM_BYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;      // bytes taken; NUM_BYTES means idle
        logic [IDX_W-1:0] idx;      // running folded index
        logic             grp;      // address bit 0
        logic             ones;     // every byte so far all ones
        logic             dvalid;
        logic             daccept;
        logic             dmcast;
    } flt_state_t;
endpackage

// File: rtl/dahf_fold.sv
// Folds one address byte into the 6-bit index, given its position.
module dahf_fold
    import dahf_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CNT_W-1:0]  pos_i,
    output logic [IDX_W-1:0]  contrib_o
);
    logic [NUM_BYTES-1:0][IDX_W-1:0] parts;

    for (genvar gp = 0; gp < NUM_BYTES; gp++) begin : g_pos
        logic [IDX_W-1:0] part;
        always_comb begin
            part = '0;
            for (int j = 0; j < BYTE_W; j++) begin
                part[(gp * BYTE_W + j) % IDX_W] = part[(gp * BYTE_W + j) % IDX_W] ^ byte_i[j];
            end
        end
        assign parts[gp] = part;
    end

    always_comb begin
        contrib_o = '0;
        for (int p = 0; p < NUM_BYTES; p++) begin
            if (pos_i == CNT_W'(p)) contrib_o = parts[p];
        end
    end
endmodule

// File: rtl/dahf_lookup.sv
// Selects the table bit addressed by the folded index.
module dahf_lookup
    import dahf_pkg::*;
(
    input  logic [WORD_W-1:0] lo_i,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              hit_o
);
    logic [HASH_BITS-1:0] table_w;
    assign table_w = {hi_i, lo_i};
    assign hit_o   = table_w[idx_i];
endmodule

// File: rtl/dahf_decide.sv
// Qualifies a table hit with group bit, enables and overrides.
module dahf_decide (
    input  logic grp_i,
    input  logic bcast_i,
    input  logic hit_i,
    input  logic uni_en_i,
    input  logic multi_en_i,
    input  logic copy_all_i,
    input  logic bcast_rej_i,
    output logic accept_o
);
    logic uni_ok, multi_ok, bcast_ok;

    always_comb begin
        uni_ok   = !grp_i && uni_en_i && hit_i;
        multi_ok = grp_i && multi_en_i && hit_i;
        bcast_ok = bcast_i && !bcast_rej_i;
        accept_o = copy_all_i || bcast_ok || uni_ok || multi_ok;
    end
endmodule

// File: rtl/dahash_filter.sv
module dahash_filter
    import dahf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cfg_uni_en,
    input  logic              cfg_multi_en,
    input  logic              cfg_copy_all,
    input  logic              cfg_bcast_reject,
    input  logic [WORD_W-1:0] hash_lo,
    input  logic [WORD_W-1:0] hash_hi,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_multicast
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NUM_BYTES - 1);
    localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(NUM_BYTES);

    flt_state_t q, d;

    logic             take;
    logic [CNT_W-1:0] pos;
    logic [IDX_W-1:0] contrib;
    logic [IDX_W-1:0] new_idx;
    logic             new_grp;
    logic             new_ones;
    logic             hit;
    logic             accept;

    assign take     = rx_valid && (rx_sof || (q.cnt < IDLE_CNT));
    assign pos      = rx_sof ? '0 : q.cnt;
    assign new_idx  = (rx_sof ? '0 : q.idx) ^ contrib;
    assign new_grp  = (pos == '0) ? rx_byte[0] : q.grp;
    assign new_ones = (rx_sof ? 1'b1 : q.ones) && (&rx_byte);

    dahf_fold u_fold (
        .byte_i    (rx_byte),
        .pos_i     (pos),
        .contrib_o (contrib)
    );

    dahf_lookup u_lookup (
        .lo_i  (hash_lo),
        .hi_i  (hash_hi),
        .idx_i (new_idx),
        .hit_o (hit)
    );

    dahf_decide u_decide (
        .grp_i       (new_grp),
        .bcast_i     (new_ones),
        .hit_i       (hit),
        .uni_en_i    (cfg_uni_en),
        .multi_en_i  (cfg_multi_en),
        .copy_all_i  (cfg_copy_all),
        .bcast_rej_i (cfg_bcast_reject),
        .accept_o    (accept)
    );

    always_comb begin
        d         = q;
        d.dvalid  = 1'b0;
        d.daccept = 1'b0;
        d.dmcast  = 1'b0;
        if (take) begin
            d.cnt  = pos + 1'b1;
            d.idx  = new_idx;
            d.grp  = new_grp;
            d.ones = new_ones;
            if (pos == LAST_POS) begin
                d.dvalid  = 1'b1;
                d.daccept = accept;
                d.dmcast  = new_grp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: IDLE_CNT, idx: '0, grp: 1'b0, ones: 1'b0,
                   dvalid: 1'b0, daccept: 1'b0, dmcast: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dec_valid     = q.dvalid;
    assign dec_accept    = q.daccept;
    assign dec_multicast = q.dmcast;
endmodule

// File: rtl/dahf_checker.sv
module dahf_checker
    import dahf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cfg_uni_en,
    input  logic              cfg_multi_en,
    input  logic              cfg_copy_all,
    input  logic              cfg_bcast_reject,
    input  logic [WORD_W-1:0] hash_lo,
    input  logic [WORD_W-1:0] hash_hi,
    input  logic              dec_valid,
    input  logic              dec_accept,
    input  logic              dec_multicast
);
    AST_ACCEPT_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid); // R10
    AST_GROUP_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_multicast |-> dec_valid); // R10
    AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R2
    AST_STROBE_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid)); // R2
    AST_COPY_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_copy_all)) |-> dec_accept); // R8
    AST_UNICAST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_multicast && !$past(cfg_uni_en) && !$past(cfg_copy_all))
        |-> !dec_accept); // R6
    AST_FULL_TABLE_ALL_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_multicast && $past(cfg_multi_en) && $past(&{hash_hi, hash_lo}))
        |-> dec_accept); // R7
    AST_MCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_multicast && !$past(cfg_multi_en) && !$past(cfg_copy_all)
         && $past(cfg_bcast_reject)) |-> !dec_accept); // R5
endmodule

bind dahash_filter dahf_checker u_dahf_checker (.*);

// File: tb/dahash_filter_tb_top.sv
`timescale 1ns/1ps
module dahash_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cfg_uni_en = 1'b0, cfg_multi_en = 1'b0;
    logic        cfg_copy_all = 1'b0, cfg_bcast_reject = 1'b0;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic        dec_valid, dec_accept, dec_multicast;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;  // 50 MHz

    dahash_filter dut_i (.*);

    function automatic logic [5:0] mdl_idx(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int k = 0; k < 6; k++)
            for (int m = 0; m < 8; m++) r[k] = r[k] ^ a[k + 6 * m];
        return r;
    endfunction

    function automatic logic mdl_acc(input logic [47:0] a);
        logic [63:0] t = {hash_hi, hash_lo};
        logic hit = t[mdl_idx(a)];
        return cfg_copy_all || ((&a) && !cfg_bcast_reject) ||
               (a[0] && cfg_multi_en && hit) || (!a[0] && cfg_uni_en && hit);
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_byte(input logic [7:0] b, input logic sof);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_sof   = sof;
        rx_byte  = b;
    endtask

    task automatic go_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_sof   = 1'b0;
        end
    endtask

    // Sends an address; returns at the negedge after the sixth byte was sampled.
    task automatic send_addr(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            drive_byte(a[8 * i +: 8], i == 0);
            if (i < 5 && gap > 0) go_idle(gap);
        end
        go_idle(1);
    endtask

    task automatic check_dec(input string tag, input logic acc, input logic mc);
        check({tag, " strobe"}, dec_valid, 1'b1);
        check({tag, " accept"}, dec_accept, acc);
        check({tag, " group"}, dec_multicast, mc);
        @(negedge clk);
        check({tag, " strobe width R2"}, dec_valid, 1'b0);
    endtask

    task automatic frame_vs_model(input string tag, input logic [47:0] a, input int gap);
        logic exp_acc = mdl_acc(a);
        send_addr(a, gap);
        check_dec(tag, exp_acc, a[0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [47:0] b;
        repeat (3) @(negedge clk);
        check("R1 reset strobe", dec_valid, 1'b0);
        check("R1 reset accept", dec_accept, 1'b0);
        check("R1 reset group", dec_multicast, 1'b0);
        rst_n = 1'b1;

        // R1: bytes without a start marker are ignored
        cfg_copy_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            drive_byte(8'hA5, 1'b0);
            check("R1 no sof no decision", dec_valid, 1'b0);
        end
        go_idle(1);
        check("R1 no sof no decision", dec_valid, 1'b0);

        // R2: trailing bytes after the address give no decision
        send_addr(48'h0123_4567_89AB, 0);
        check_dec("R8 copy-all", 1'b1, 1'b1);
        for (int i = 0; i < 7; i++) begin
            drive_byte(8'hFF, 1'b0);
            check("R2 trailing bytes", dec_valid, 1'b0);
        end
        go_idle(2);
        check("R2 trailing bytes", dec_valid, 1'b0);

        // R8: copy-all with empty table, unicast
        hash_lo = '0; hash_hi = '0; cfg_uni_en = 1'b0; cfg_multi_en = 1'b0;
        cfg_bcast_reject = 1'b1;
        send_addr(48'h5566_7788_9A02, 0);
        check_dec("R8 copy-all unicast", 1'b1, 1'b0);
        cfg_copy_all = 1'b0;
        send_addr(48'h5566_7788_9A02, 0);
        check_dec("R6 no enable", 1'b0, 1'b0);

        // R9: broadcast
        cfg_bcast_reject = 1'b0;
        send_addr('1, 0);
        check_dec("R9 broadcast accepted", 1'b1, 1'b1);
        cfg_bcast_reject = 1'b1;
        send_addr('1, 0);
        check_dec("R9 broadcast rejected", 1'b0, 1'b1);
        cfg_multi_en = 1'b1; hash_hi = 32'h8000_0000;  // index of all-ones is 0
        send_addr('1, 0);
        check_dec("R9 broadcast miss via hash", 1'b0, 1'b1);
        hash_hi = '0; hash_lo = 32'h0000_0001;
        send_addr('1, 0);
        check_dec("R9 broadcast hit via hash", 1'b1, 1'b1);

        // R7: full table with multicast enable only
        hash_lo = '1; hash_hi = '1; cfg_uni_en = 1'b0; cfg_multi_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            seed = nxt(seed); a[31:0] = seed;
            seed = nxt(seed); a[47:32] = seed[15:0];
            a[0] = i[0];
            send_addr(a, 0);
            check_dec("R7 full table", a[0], a[0]);
        end

        // R3 R4 R5 R6 R10: every index pattern in every 6-bit slot
        cfg_uni_en = 1'b1; cfg_multi_en = 1'b1; cfg_bcast_reject = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 64; v++) begin
                a = 48'(v) << (6 * m);
                {hash_hi, hash_lo} = 64'd1 << v;
                send_addr(a, 0);
                check_dec("R3 R4 index hit", 1'b1, a[0]);
                {hash_hi, hash_lo} = 64'd1 << (v ^ 1);
                send_addr(a, 0);
                check_dec("R4 index neighbour miss", 1'b0, a[0]);
            end
        end

        // R5 R6 R10: pseudo-random addresses, tables and settings against the model
        for (int i = 0; i < 300; i++) begin
            seed = nxt(seed); hash_lo = seed;
            seed = nxt(seed); hash_hi = seed;
            seed = nxt(seed); a[31:0] = seed;
            cfg_uni_en = seed[3]; cfg_multi_en = seed[7]; cfg_bcast_reject = seed[11];
            cfg_copy_all = (seed[20:17] == 4'd0);
            seed = nxt(seed); a[47:32] = seed[15:0];
            if (i % 16 == 5) a = '1;
            frame_vs_model("R5 R6 R10 mixed", a, 0);
        end

        // R11: gaps and restart
        cfg_copy_all = 1'b0; cfg_bcast_reject = 1'b1;
        cfg_uni_en = 1'b1; cfg_multi_en = 1'b1;
        hash_lo = 32'h0F0F_3C3C; hash_hi = 32'h9669_A55A;
        frame_vs_model("R11 gap one", 48'h8844_2211_7733, 1);
        frame_vs_model("R11 gap three", 48'h1357_9BDF_0246, 3);
        a = 48'hFFFF_FFFF_FF01;
        b = 48'h0000_0000_0000;
        {hash_hi, hash_lo} = '0;
        {hash_hi, hash_lo} = 64'd1 << mdl_idx(a);
        for (int i = 0; i < 4; i++) begin
            drive_byte(a[8 * i +: 8], i == 0);
        end
        for (int i = 0; i < 6; i++) begin
            drive_byte(b[8 * i +: 8], i == 0);
            check("R11 restart no early strobe", dec_valid, 1'b0);
        end
        go_idle(1);
        check_dec("R11 restart uses new address", mdl_acc(b), 1'b0);

        // R12: settings sampled at the edge taking the sixth byte
        {hash_hi, hash_lo} = '0;
        cfg_copy_all = 1'b0;
        a = 48'h3141_5926_5358;
        for (int i = 0; i < 5; i++) drive_byte(a[8 * i +: 8], i == 0);
        drive_byte(a[47:40], 1'b0);
        cfg_copy_all = 1'b1;
        go_idle(1);
        cfg_copy_all = 1'b0;
        check_dec("R12 late set counts", 1'b1, 1'b0);
        cfg_copy_all = 1'b1;
        for (int i = 0; i < 5; i++) drive_byte(a[8 * i +: 8], i == 0);
        drive_byte(a[47:40], 1'b0);
        cfg_copy_all = 1'b0;
        go_idle(1);
        check_dec("R12 clear at edge counts", 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule